// File: doc/BRIEF.md
# Framed Manchester Identifier Decoder

This block sits behind a frequency-shift demodulator that has already reduced the carrier to one half-bit symbol per strobe. It watches that symbol stream for a six-symbol framing marker. Once it has seen the marker, it takes the following symbols two at a time and turns each Manchester pair into a data bit. The bits are shifted into a 64-bit identifier accumulator, most significant bit first.

The frame is closed by the next marker. At that point the assembled identifier is published, but only if it holds at least one set bit. A one-cycle strobe announces the new value. A malformed pair abandons the frame, and the decoder goes back to hunting for a marker. A 16-bit card-number field is sliced from the published identifier for downstream use.

Top module: `mframe_id_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registered outputs clear: `id_out` becomes zero and `id_valid` becomes low.
- R2: A marker is recognised when the six most recent accepted symbols, oldest first, are 1,1,1,0,0,0. Recognition can happen at any symbol position, and it starts pair decoding with the next symbol.
- R3: After a marker, symbols are taken in non-overlapping pairs, first symbol first. The pair 0,1 yields data bit 1 and the pair 1,0 yields data bit 0.
- R4: Data bits enter the accumulator at bit 0, and older bits move toward bit 63. When a frame has more than 64 bits, only the 64 most recent remain.
- R5: When a marker completes while a frame is being decoded and the accumulator is non-zero, `id_out` takes the accumulator value and `id_valid` is high. Both appear in the cycle after the edge that accepted the marker's last symbol. The accumulator then restarts from zero.
- R6: When a frame closes with an all-zero accumulator, `id_valid` stays low and `id_out` keeps its previous value.
- R7: A pair 0,0 at a pair boundary abandons the frame. The marker that follows produces no output.
- R8: A pair 1,1 at a pair boundary is held as the possible start of a marker. If the next four symbols are 1,0,0,0, the frame closes as in R5. If any of them differs, the frame is abandoned.
- R9: `card_num` always equals bits 16 down to 1 of `id_out`.
- R10: `id_valid` is never high for two consecutive cycles, and `id_out` changes only in a cycle where `id_valid` is high.
- R11: When `sym_valid` is low, `sym_data` has no effect, and `id_valid` is low in the following cycle.
- R12: A marker seen while no frame is being decoded (after reset or after an abandoned frame) produces no output. It only starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | Qualifies `sym_data` for one cycle |
| sym_data | input | 1 | Half-bit symbol value |
| id_out | output | 64 | Last published identifier |
| id_valid | output | 1 | One-cycle strobe when `id_out` is updated |
| card_num | output | 16 | Bits 16..1 of `id_out` |

## Verification
Directed frames cover the cases the requirements single out:
- a short alternating pattern, which tells the 0,1 and 1,0 decoding apart and confirms the card slice;
- a 70-bit frame, which shows that the oldest bits fall off the top;
- an all-zero frame, which must stay silent;
- a 0,0 pair and a broken 1,1 lead-in, each of which must kill the frame;
- a marker straight after reset, which must only arm the decoder.

Random frames of 1 to 72 bits follow, with occasional injected bad pairs and idle gaps carrying random data. Each is compared symbol by symbol against a bench model of the framing rules. This separates correct pair alignment and marker priority from designs that slip a symbol, emit on a stale frame or react to unqualified data.

// File: rtl/mfd_pkg.sv
// Package: shared types for the framed Manchester identifier decoder.
// Assumes: nothing beyond the standard types.
package mfd_pkg;

    // Pair-decoder states: hunting for a marker, decoding pairs, or
    // following a 1,1 pair that may be the head of a closing marker.
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_DECODE = 2'd1,
        ST_PEND   = 2'd2
    } mfd_state_e;

endpackage

// File: rtl/mfd_marker_detect.sv
// Module: mfd_marker_detect
// Keeps a sliding window of the last MARK_LEN accepted symbols. It flags a
// hit in the same cycle as the symbol that completes MARK_PAT (oldest
// symbol in the MSB).
// Assumes: sym_data matters only while sym_valid is high.
module mfd_marker_detect #(
    parameter int                  MARK_LEN = 6,
    parameter logic [MARK_LEN-1:0] MARK_PAT = 6'b111000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_data,
    output logic mark_hit
);

    logic [MARK_LEN-1:0] hist_q;
    logic [MARK_LEN-1:0] hist_next;

    // Window after the incoming symbol is appended.
    always_comb begin
        hist_next = {hist_q[MARK_LEN-2:0], sym_data};
    end

    // Advance the window on each accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (sym_valid) begin
            hist_q <= hist_next;
        end
    end

    // Marker completes with the current symbol.
    always_comb begin
        mark_hit = sym_valid && (hist_next == MARK_PAT);
    end

endmodule

// File: rtl/mfd_pair_fsm.sv
// Module: mfd_pair_fsm
// Tracks frame state and pair alignment. It turns 0,1 and 1,0 pairs into
// data bits, holds a 1,1 pair while the rest of a marker may follow, and
// abandons the frame on any other pattern. A marker hit always wins and
// realigns the pairs.
// Assumes: mark_hit comes from a window fed by the same symbol stream, and
// MARK_PAT begins with 1,1 so a closing marker shows up as a 1,1 pair.
module mfd_pair_fsm
    import mfd_pkg::*;
#(
    parameter int                  MARK_LEN = 6,
    parameter logic [MARK_LEN-1:0] MARK_PAT = 6'b111000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_data,
    input  logic mark_hit,
    output logic bit_valid,
    output logic bit_val,
    output logic frame_drop,
    output logic frame_live
);

    localparam int PEND_LEN = MARK_LEN - 2;
    localparam int CNT_W    = (PEND_LEN > 1) ? $clog2(PEND_LEN) : 1;

    mfd_state_e       state_q, state_d;
    logic             phase_q, phase_d;
    logic             first_q, first_d;
    logic [CNT_W-1:0] cnt_q,   cnt_d;
    int               pend_idx;

    // Position in MARK_PAT of the symbol expected next while pending.
    always_comb begin
        pend_idx = PEND_LEN - 1 - int'(cnt_q);
    end

    // Next-state and per-symbol outputs.
    always_comb begin
        state_d    = state_q;
        phase_d    = phase_q;
        first_d    = first_q;
        cnt_d      = cnt_q;
        bit_valid  = 1'b0;
        bit_val    = 1'b0;
        frame_drop = 1'b0;
        if (sym_valid) begin
            if (mark_hit) begin
                state_d = ST_DECODE;
                phase_d = 1'b0;
                cnt_d   = '0;
            end else begin
                case (state_q)
                    ST_DECODE: begin
                        if (!phase_q) begin
                            first_d = sym_data;
                            phase_d = 1'b1;
                        end else begin
                            phase_d = 1'b0;
                            if (first_q != sym_data) begin
                                bit_valid = 1'b1;
                                bit_val   = sym_data;
                            end else if (first_q) begin
                                state_d = ST_PEND;
                                cnt_d   = '0;
                            end else begin
                                state_d    = ST_SEARCH;
                                frame_drop = 1'b1;
                            end
                        end
                    end
                    ST_PEND: begin
                        if (sym_data != MARK_PAT[pend_idx]) begin
                            state_d    = ST_SEARCH;
                            frame_drop = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    ST_SEARCH: begin
                        state_d = ST_SEARCH;
                    end
                    default: begin
                        state_d = ST_SEARCH;
                    end
                endcase
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            phase_q <= 1'b0;
            first_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            first_q <= first_d;
            cnt_q   <= cnt_d;
        end
    end

    // A frame is open whenever the decoder is not searching.
    always_comb begin
        frame_live = (state_q != ST_SEARCH);
    end

endmodule

// File: rtl/mfd_id_accum.sv
// Module: mfd_id_accum
// Shifts decoded bits into an ID_W-bit accumulator, MSB first. On a marker
// that closes an open frame, it publishes a non-zero accumulator with a
// one-cycle strobe. The accumulator clears on every marker and every drop.
// Assumes: mark_hit, frame_drop and bit_valid are never high together.
module mfd_id_accum #(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mark_hit,
    input  logic            frame_live,
    input  logic            frame_drop,
    input  logic            bit_valid,
    input  logic            bit_val,
    output logic [ID_W-1:0] id_q,
    output logic            id_pulse
);

    logic [ID_W-1:0] acc_q;
    logic            publish;

    // Publish only when closing an open frame with some bit set.
    always_comb begin
        publish = mark_hit && frame_live && (|acc_q);
    end

    // Accumulator: clear on marker or drop, otherwise shift in new bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (mark_hit || frame_drop) begin
            acc_q <= '0;
        end else if (bit_valid) begin
            acc_q <= {acc_q[ID_W-2:0], bit_val};
        end
    end

    // Output register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q     <= '0;
            id_pulse <= 1'b0;
        end else begin
            id_pulse <= publish;
            if (publish) begin
                id_q <= acc_q;
            end
        end
    end

endmodule

// File: rtl/mframe_id_decoder.sv
// Module: mframe_id_decoder (top)
// Recovers framed Manchester identifiers from a half-bit symbol stream and
// presents the last non-zero identifier with a one-cycle strobe and a card
// number slice.
// Assumes: one symbol per cycle at most, qualified by sym_valid.
module mframe_id_decoder #(
    parameter int                  ID_W     = 64,
    parameter int                  CARD_W   = 16,
    parameter int                  CARD_LSB = 1,
    parameter int                  MARK_LEN = 6,
    parameter logic [MARK_LEN-1:0] MARK_PAT = 6'b111000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic              sym_data,
    output logic [ID_W-1:0]   id_out,
    output logic              id_valid,
    output logic [CARD_W-1:0] card_num
);

    logic mark_hit;
    logic bit_valid;
    logic bit_val;
    logic frame_drop;
    logic frame_live;

    mfd_marker_detect #(
        .MARK_LEN (MARK_LEN),
        .MARK_PAT (MARK_PAT)
    ) u_mark (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_data  (sym_data),
        .mark_hit  (mark_hit)
    );

    mfd_pair_fsm #(
        .MARK_LEN (MARK_LEN),
        .MARK_PAT (MARK_PAT)
    ) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .sym_data   (sym_data),
        .mark_hit   (mark_hit),
        .bit_valid  (bit_valid),
        .bit_val    (bit_val),
        .frame_drop (frame_drop),
        .frame_live (frame_live)
    );

    mfd_id_accum #(
        .ID_W (ID_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_hit   (mark_hit),
        .frame_live (frame_live),
        .frame_drop (frame_drop),
        .bit_valid  (bit_valid),
        .bit_val    (bit_val),
        .id_q       (id_out),
        .id_pulse   (id_valid)
    );

    // Card number slice of the published identifier.
    always_comb begin
        card_num = id_out[CARD_LSB +: CARD_W];
    end

endmodule

// File: rtl/mframe_id_decoder_chk.sv
// Module: mframe_id_decoder_chk
// Port-level temporal checks, bound into every mframe_id_decoder instance.
// Assumes: synchronous active-low reset.
module mframe_id_decoder_chk #(
    parameter int ID_W   = 64,
    parameter int CARD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_valid,
    input logic              sym_data,
    input logic [ID_W-1:0]   id_out,
    input logic              id_valid,
    input logic [CARD_W-1:0] card_num
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (id_out == '0 && !id_valid)); // R1

    AST_MARK_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> !$past(sym_data)); // R2

    AST_PUBLISH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (id_out != '0)); // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> !id_valid); // R10

    AST_ID_CHANGES_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_out) |-> id_valid); // R10

    AST_STROBE_NEEDS_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> $past(sym_valid)); // R11

endmodule

bind mframe_id_decoder mframe_id_decoder_chk #(
    .ID_W   (ID_W),
    .CARD_W (CARD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .id_out    (id_out),
    .id_valid  (id_valid),
    .card_num  (card_num)
);

// File: tb/mframe_id_decoder_bench.sv
`timescale 1ns/1ps
module mframe_id_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic        sym_data = 1'b0;
    logic [63:0] id_out;
    logic        id_valid;
    logic [15:0] card_num;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [5:0]  m_hist = '0;
    int          m_st   = 0;     // 0 search, 1 decode, 2 pending
    bit          m_ph   = 1'b0;
    bit          m_prev = 1'b0;
    int          m_pc   = 0;
    logic [63:0] m_acc  = '0;
    logic [63:0] e_id   = '0;
    bit          e_val  = 1'b0;
    string       cur_tag = "R5";

    always #2 clk = ~clk;

    mframe_id_decoder u_mframe_id_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_data  (sym_data),
        .id_out    (id_out),
        .id_valid  (id_valid),
        .card_num  (card_num)
    );

    function automatic logic [15:0] exp_card(input logic [63:0] v); // R9
        return v[16:1];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Framing rules of R2..R8 and R12, applied to one accepted symbol
    task automatic ref_step(input bit s);
        bit pexp;
        m_hist = {m_hist[4:0], s};
        e_val  = 1'b0;
        if (m_hist == 6'b111000) begin
            if (m_st != 0 && m_acc != 0) begin
                e_id  = m_acc;
                e_val = 1'b1;
            end
            m_acc = '0;
            m_st  = 1;
            m_ph  = 1'b0;
        end else if (m_st == 1) begin
            if (!m_ph) begin
                m_prev = s;
                m_ph   = 1'b1;
            end else begin
                m_ph = 1'b0;
                if (m_prev != s) m_acc = {m_acc[62:0], s};
                else if (m_prev) begin m_st = 2; m_pc = 0; end
                else begin m_st = 0; m_acc = '0; end
            end
        end else if (m_st == 2) begin
            pexp = (m_pc == 0);
            if (s != pexp) begin m_st = 0; m_acc = '0; end
            else m_pc++;
        end
    endtask

    task automatic compare_outputs(input string tag);
        check(id_valid == e_val, tag, "id_valid", 64'(id_valid), 64'(e_val));
        check(id_out == e_id, tag, "id_out", id_out, e_id);
        check(card_num == exp_card(e_id), "R9", "card_num", 64'(card_num), 64'(exp_card(e_id)));
    endtask

    // Idle cycle with random unqualified data: R11
    task automatic idle_cycle();
        sym_valid = 1'b0;
        sym_data  = 1'($urandom);
        @(posedge clk);
        @(negedge clk);
        check(!id_valid, "R11", "idle id_valid", 64'(id_valid), 64'd0);
        check(id_out == e_id, "R11", "idle id_out", id_out, e_id);
    endtask

    task automatic send_sym(input bit s, input bit gaps);
        if (gaps && $urandom_range(0, 3) == 0) idle_cycle();
        sym_valid = 1'b1;
        sym_data  = s;
        @(posedge clk);
        ref_step(s);
        @(negedge clk);
        sym_valid = 1'b0;
        compare_outputs(cur_tag);
    endtask

    task automatic send_marker(input bit gaps);
        send_sym(1, gaps); send_sym(1, gaps); send_sym(1, gaps);
        send_sym(0, gaps); send_sym(0, gaps); send_sym(0, gaps);
    endtask

    // Data bit 1 -> pair 0,1 ; data bit 0 -> pair 1,0 (R3), MSB first (R4)
    task automatic send_bits(input logic [127:0] v, input int n, input bit gaps);
        for (int i = n - 1; i >= 0; i--) begin
            send_sym(!v[i], gaps);
            send_sym(v[i], gaps);
        end
    endtask

    initial begin
        logic [63:0] held;
        void'($urandom(32'h1D5EED01));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(id_out == 64'd0, "R1", "reset id_out", id_out, 64'd0);
        check(!id_valid, "R1", "reset id_valid", 64'(id_valid), 64'd0);
        check(card_num == 16'd0, "R1", "reset card_num", 64'(card_num), 64'd0);
        rst_n = 1'b1;

        // R12: marker straight after reset only arms the decoder
        cur_tag = "R12";
        send_marker(0);
        check(!id_valid, "R12", "marker from search", 64'(id_valid), 64'd0);

        // R3/R5/R9: 8-bit pattern 0xA5, closed by a marker
        cur_tag = "R3";
        send_bits(128'hA5, 8, 0);
        cur_tag = "R5";
        send_marker(0);
        check(id_valid && id_out == 64'hA5, "R5", "close A5", id_out, 64'hA5);
        check(card_num == 16'h0052, "R9", "card of A5", 64'(card_num), 64'h52);
        cur_tag = "R10";
        idle_cycle();
        check(!id_valid && id_out == 64'hA5, "R10", "strobe drop/hold", id_out, 64'hA5);

        // R6: all-zero frame publishes nothing
        cur_tag = "R6";
        send_bits(128'h0, 10, 0);
        send_marker(0);
        check(!id_valid && id_out == 64'hA5, "R6", "zero frame", id_out, 64'hA5);

        // R4: 70-bit frame keeps the 64 most recent bits
        cur_tag = "R4";
        send_bits({58'd0, 6'b111111, 64'h0123456789ABCDEF}, 70, 0);
        send_marker(0);
        check(id_valid && id_out == 64'h0123456789ABCDEF, "R4", "overlength", id_out, 64'h0123456789ABCDEF);

        // R7: 0,0 pair abandons the frame
        cur_tag = "R7";
        held = id_out;
        send_bits(128'h3C, 8, 0);
        send_sym(0, 0); send_sym(0, 0);
        send_bits(128'h5, 4, 0);
        send_marker(0);
        check(!id_valid && id_out == held, "R7", "dropped by 00", id_out, held);

        // R8: broken 1,1 lead-in abandons the frame
        cur_tag = "R8";
        send_bits(128'h3C, 8, 0);
        send_sym(1, 0); send_sym(1, 0); send_sym(0, 0); send_sym(1, 0);
        send_marker(0);
        check(!id_valid && id_out == held, "R8", "broken lead-in", id_out, held);
        // R8 positive: frame closed through the pending path
        send_bits(128'h1B7, 9, 0);
        send_marker(0);
        check(id_valid && id_out == 64'h1B7, "R8", "pending close", id_out, 64'h1B7);

        // Random frames with gaps and occasional bad pairs
        cur_tag = "R5";
        for (int f = 0; f < 250; f++) begin
            logic [127:0] v;
            int len;
            int bad;
            v   = {$urandom, $urandom, $urandom, $urandom};
            len = $urandom_range(1, 72);
            bad = ($urandom_range(0, 5) == 0) ? $urandom_range(0, len - 1) : -1;
            for (int i = len - 1; i >= 0; i--) begin
                if (i == bad) begin
                    bit b = 1'($urandom);
                    send_sym(b, 1); send_sym(b, 1);
                end
                send_sym(!v[i], 1);
                send_sym(v[i], 1);
            end
            send_marker(1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule